// File: doc/BRIEF.md
# Interlaced Composite Sync Generator

This block produces every digital timing signal a 2:1 interlaced television raster needs. It is clocked by one master clock running at 32 times the line rate and counts the raster in half-lines of 16 clocks. From that count it decodes five outputs:

- composite sync, including the vertical interval with its equalizing and serrated broad pulses;
- horizontal drive;
- vertical drive;
- a frame marker at the start of the odd field;
- a field flag.

A static input chooses a 525-line or a 625-line frame. A one-cycle vertical reset request moves the vertical count to the first equalizing pulse or to the first broad pulse. The request takes effect on the next half-line boundary, so horizontal phase is never disturbed.

A reference sync input is watched continuously. Once enough evenly spaced reference pulses have arrived, the block declares lock. While locked, each qualifying reference pulse pulls the line counter to the start of a line. When the reference falls quiet for eight lines, lock is dropped and the generator free-runs from its own clock. Every sync output is active-low. The block has no data stream, so all of its pins are plain control and status signals.

Top module: `csync_gen`

## Requirements
- R1: While reset is held, the raster position is line start of half-line 0 of the odd field. In that state `csync_n`, `hdrive_n`, `vdrive_n` and `frame_n` are 0, `field` is 0 and `genlocked` is 0.
- R2: A line is 32 clocks, with line clock 0 at line start. `hdrive_n` is 0 on line clocks 0 and 1 of every line and 1 elsewhere.
- R3: A field holds 525 half-lines when `lines625`=0 and 625 half-lines when `lines625`=1. `field` is 0 in the odd field and 1 in the even field. The odd field begins at a line start and the even field begins at mid-line (line clock 16).
- R4: The half-lines numbered 0-5 and 12-17 of each field carry equalizing pulses. In each of them `csync_n` is 0 only on half-line clock 0 of the 16.
- R5: Half-lines 6-11 carry serrated broad pulses. In each of them `csync_n` is 0 on half-line clocks 0 to 13 and 1 on clocks 14 and 15.
- R6: Outside half-lines 0-17, `csync_n` is 0 only on line clocks 0 and 1.
- R7: `vdrive_n` is 0 exactly during half-lines 0-17 of each field.
- R8: `frame_n` is 0 during half-line 0 of the odd field only.
- R9: A `vreset` pulse is held pending until the next half-line boundary. At that boundary the half-line count loads 6 if `vreset_at_vsync`=1 and 0 otherwise. `field` becomes 0 if the boundary is a line start and 1 if it is mid-line.
- R10: Falling edges of `ref_sync_n` are timed against one another. An interval of 31, 32 or 33 clocks counts as good; any other interval clears the run. `genlocked` rises in the clock after the falling edge that completes four consecutive good intervals.
- R11: While `genlocked` is 1, a falling edge that ends a good interval puts the line counter at line clock 0 in the next clock. `hdrive_n` is therefore 0 for the two clocks that follow that edge.
- R12: `genlocked` falls 256 clocks (eight lines) after the last falling edge of `ref_sync_n` when no further edge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 32 times the line rate |
| rst_n | input | 1 | Active-low synchronous reset |
| lines625 | input | 1 | 0: 525-line frame, 1: 625-line frame; static outside reset |
| vreset | input | 1 | Vertical reset request, one clock wide |
| vreset_at_vsync | input | 1 | Reset target: 0 first equalizing pulse, 1 first broad pulse |
| ref_sync_n | input | 1 | Reference sync, active-low, synchronous to clk |
| csync_n | output | 1 | Composite sync, active-low |
| hdrive_n | output | 1 | Horizontal drive, active-low |
| vdrive_n | output | 1 | Vertical drive, active-low |
| frame_n | output | 1 | Odd-field start marker, active-low |
| field | output | 1 | 0 odd field, 1 even field |
| genlocked | output | 1 | 1 while the reference is accepted |

## Verification
The assertions rely on a few assumptions about the inputs:

- `ref_sync_n` is already synchronous to `clk`.
- `lines625` changes only while reset is held.
- `vreset` is a single-clock request.

Under these assumptions the field length never shrinks below the live half-line count, and the line counter advances by one except in an alignment clock. The stimulus drives every input at the falling clock edge and changes the mode only inside reset. Random vertical resets, each with a random target, are spread across long free-running stretches. The reference pulse train is directed, with spacings chosen to sit on both edges of the acceptance window and just outside it.

// File: rtl/csg_pkg.sv
package csg_pkg;
  // Position of a half-line within the field, as seen by the sync decoder.
  typedef enum logic [1:0] {
    RGN_PRE_EQ,
    RGN_BROAD,
    RGN_POST_EQ,
    RGN_PICTURE
  } rgn_t;
endpackage

// File: rtl/csg_timebase.sv
module csg_timebase #(
  parameter int LINE_CLKS = 32,
  parameter int PIX_W     = $clog2(LINE_CLKS),
  parameter int HL_A      = 525,
  parameter int HL_B      = 625,
  parameter int HIDX_W    = 10,
  parameter int VS_START  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_b,
  input  logic              vreset,
  input  logic              vreset_sel,
  input  logic              align,
  output logic [PIX_W-1:0]  pix,
  output logic [HIDX_W-1:0] hidx,
  output logic              field
);
  localparam int HALF = LINE_CLKS / 2;
  localparam logic [PIX_W-1:0]  PIX_LAST = PIX_W'(LINE_CLKS - 1);
  localparam logic [PIX_W-1:0]  PIX_HALF = PIX_W'(HALF);
  localparam logic [HIDX_W-1:0] LOAD_VS  = HIDX_W'(VS_START);

  logic [PIX_W-1:0]  nxt_pix;
  logic [HIDX_W-1:0] last_hidx;
  logic              boundary, load_req, pend;

  assign last_hidx = sel_b ? HIDX_W'(HL_B - 1) : HIDX_W'(HL_A - 1);
  assign load_req  = pend | vreset;

  always_comb begin
    if (align)                 nxt_pix = '0;
    else if (pix == PIX_LAST)  nxt_pix = '0;
    else                       nxt_pix = pix + 1'b1;
  end

  // A half-line ends whenever the line counter moves into the other half.
  assign boundary = (nxt_pix >= PIX_HALF) != (pix >= PIX_HALF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix   <= '0;
      hidx  <= '0;
      field <= 1'b0;
      pend  <= 1'b0;
    end else begin
      pix  <= nxt_pix;
      pend <= load_req & ~boundary;
      if (boundary) begin
        if (load_req) begin
          hidx  <= vreset_sel ? LOAD_VS : '0;
          field <= (nxt_pix != '0);
        end else if (hidx == last_hidx) begin
          hidx  <= '0;
          field <= ~field;
        end else begin
          hidx <= hidx + 1'b1;
        end
      end
    end
  end

  assert_line_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !align |=> pix == (($past(pix) == PIX_LAST) ? '0 : $past(pix) + 1'b1));
  assert_align_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    align |=> pix == '0);
  assert_hidx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hidx <= last_hidx);
  assert_field_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(field) |-> (hidx == '0 || hidx == LOAD_VS));
  assert_vreset_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && load_req) |=> hidx == ($past(vreset_sel) ? LOAD_VS : '0));
endmodule

// File: rtl/csg_decode.sv
module csg_decode
  import csg_pkg::*;
#(
  parameter int LINE_CLKS = 32,
  parameter int PIX_W     = $clog2(LINE_CLKS),
  parameter int HIDX_W    = 10,
  parameter int HS_CLKS   = 2,
  parameter int EQ_CLKS   = 1,
  parameter int SERR_CLKS = 2,
  parameter int PULSES    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIX_W-1:0]  pix,
  input  logic [HIDX_W-1:0] hidx,
  input  logic              field,
  output logic              csync_n,
  output logic              hdrive_n,
  output logic              vdrive_n,
  output logic              frame_n
);
  localparam int PH_W = PIX_W - 1;
  localparam logic [PH_W-1:0]   EQ_END    = PH_W'(EQ_CLKS);
  localparam logic [PH_W-1:0]   BROAD_END = PH_W'(LINE_CLKS / 2 - SERR_CLKS);
  localparam logic [PIX_W-1:0]  HS_END    = PIX_W'(HS_CLKS);
  localparam logic [HIDX_W-1:0] END_PRE   = HIDX_W'(PULSES);
  localparam logic [HIDX_W-1:0] END_BROAD = HIDX_W'(2 * PULSES);
  localparam logic [HIDX_W-1:0] END_POST  = HIDX_W'(3 * PULSES);

  logic [PH_W-1:0] phase;
  rgn_t            rgn;
  logic            cs_low, hs_low;

  assign phase  = pix[PH_W-1:0];
  assign hs_low = (pix < HS_END);

  always_comb begin
    if (hidx < END_PRE)        rgn = RGN_PRE_EQ;
    else if (hidx < END_BROAD) rgn = RGN_BROAD;
    else if (hidx < END_POST)  rgn = RGN_POST_EQ;
    else                       rgn = RGN_PICTURE;
  end

  always_comb begin
    unique case (rgn)
      RGN_PRE_EQ, RGN_POST_EQ: cs_low = (phase < EQ_END);
      RGN_BROAD:               cs_low = (phase < BROAD_END);
      default:                 cs_low = hs_low;
    endcase
  end

  assign csync_n  = ~cs_low;
  assign hdrive_n = ~hs_low;
  assign vdrive_n = (rgn == RGN_PICTURE);
  assign frame_n  = ~(~field && hidx == '0);

  assert_frame_in_vdrive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |-> (!vdrive_n && !field));
  assert_picture_hsync_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vdrive_n && !hdrive_n) |-> !csync_n);
  assert_vdrive_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!vdrive_n && phase == '0) |-> !csync_n);
endmodule

// File: rtl/csg_refdet.sv
module csg_refdet #(
  parameter int LINE_CLKS  = 32,
  parameter int LOCK_RUN   = 4,
  parameter int LOSS_LINES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_sync_n,
  output logic locked,
  output logic align
);
  localparam int LOSS_CLKS = LINE_CLKS * LOSS_LINES;
  localparam int CNT_W     = $clog2(LOSS_CLKS);
  localparam int RUN_W     = $clog2(LOCK_RUN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LOSS_CLKS - 1);
  localparam logic [CNT_W-1:0] WIN_LO  = CNT_W'(LINE_CLKS - 2);
  localparam logic [CNT_W-1:0] WIN_HI  = CNT_W'(LINE_CLKS);
  localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(LOCK_RUN - 1);

  logic             ref_q, fall, good;
  logic [CNT_W-1:0] cnt;
  logic [RUN_W-1:0] run;

  assign fall  = ref_q & ~ref_sync_n;
  assign good  = fall && (cnt >= WIN_LO) && (cnt <= WIN_HI);
  assign align = good & locked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q  <= 1'b1;
      cnt    <= CNT_MAX;
      run    <= '0;
      locked <= 1'b0;
    end else begin
      ref_q <= ref_sync_n;
      if (fall)                cnt <= '0;
      else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      if (fall) begin
        if (!good)              run <= '0;
        else if (run != RUN_TOP) run <= run + 1'b1;
        if (good && run == RUN_TOP) locked <= 1'b1;
      end else if (cnt == CNT_MAX) begin
        locked <= 1'b0;
        run    <= '0;
      end
    end
  end

  assert_lock_needs_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !good) |=> !locked);
  assert_keep_on_edge_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && fall) |=> locked);
  assert_run_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    run <= RUN_TOP);
endmodule

// File: rtl/csync_gen.sv
module csync_gen #(
  parameter int LINE_CLKS  = 32,
  parameter int LINES_A    = 525,
  parameter int LINES_B    = 625,
  parameter int HS_CLKS    = 2,
  parameter int EQ_CLKS    = 1,
  parameter int SERR_CLKS  = 2,
  parameter int PULSES     = 6,
  parameter int LOCK_RUN   = 4,
  parameter int LOSS_LINES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lines625,
  input  logic vreset,
  input  logic vreset_at_vsync,
  input  logic ref_sync_n,
  output logic csync_n,
  output logic hdrive_n,
  output logic vdrive_n,
  output logic frame_n,
  output logic field,
  output logic genlocked
);
  localparam int PIX_W  = $clog2(LINE_CLKS);
  localparam int HL_MAX = (LINES_A > LINES_B) ? LINES_A : LINES_B;
  localparam int HIDX_W = $clog2(HL_MAX);

  logic [PIX_W-1:0]  pix;
  logic [HIDX_W-1:0] hidx;
  logic              align;

  csg_refdet #(
    .LINE_CLKS(LINE_CLKS), .LOCK_RUN(LOCK_RUN), .LOSS_LINES(LOSS_LINES)
  ) u_refdet (
    .clk(clk), .rst_n(rst_n), .ref_sync_n(ref_sync_n),
    .locked(genlocked), .align(align)
  );

  csg_timebase #(
    .LINE_CLKS(LINE_CLKS), .PIX_W(PIX_W), .HL_A(LINES_A), .HL_B(LINES_B),
    .HIDX_W(HIDX_W), .VS_START(PULSES)
  ) u_timebase (
    .clk(clk), .rst_n(rst_n), .sel_b(lines625), .vreset(vreset),
    .vreset_sel(vreset_at_vsync), .align(align),
    .pix(pix), .hidx(hidx), .field(field)
  );

  csg_decode #(
    .LINE_CLKS(LINE_CLKS), .PIX_W(PIX_W), .HIDX_W(HIDX_W), .HS_CLKS(HS_CLKS),
    .EQ_CLKS(EQ_CLKS), .SERR_CLKS(SERR_CLKS), .PULSES(PULSES)
  ) u_decode (
    .clk(clk), .rst_n(rst_n), .pix(pix), .hidx(hidx), .field(field),
    .csync_n(csync_n), .hdrive_n(hdrive_n), .vdrive_n(vdrive_n), .frame_n(frame_n)
  );
endmodule

// File: tb/test_csync_gen.sv
`timescale 1ns/1ps
module test_csync_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lines625 = 1'b0;
  logic vreset = 1'b0;
  logic vreset_at_vsync = 1'b0;
  logic ref_sync_n = 1'b1;
  logic csync_n, hdrive_n, vdrive_n, frame_n, field, genlocked;

  int checks = 0;
  int fails = 0;
  int mp, mh, mf, mfl;
  bit mpend;

  always #2.5 clk = ~clk;

  csync_gen i_csync_gen (
    .clk(clk), .rst_n(rst_n), .lines625(lines625), .vreset(vreset),
    .vreset_at_vsync(vreset_at_vsync), .ref_sync_n(ref_sync_n),
    .csync_n(csync_n), .hdrive_n(hdrive_n), .vdrive_n(vdrive_n),
    .frame_n(frame_n), .field(field), .genlocked(genlocked)
  );

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b (line clk %0d half-line %0d)",
               tag, what, act, exp, mp, mh);
    end
  endtask

  // Expected outputs derived from the requirement text.
  function automatic logic e_cs(input int p, input int h);
    int ph = p % 16;
    if (h < 6 || (h >= 12 && h < 18)) return !(ph < 1);
    if (h < 12) return !(ph < 14);
    return !(p < 2);
  endfunction

  function automatic string cs_tag(input int h);
    if (h < 6 || (h >= 12 && h < 18)) return "R4";
    if (h < 12) return "R5";
    return "R6";
  endfunction

  task automatic compare();
    chk(csync_n, e_cs(mp, mh), cs_tag(mh), "csync_n");
    chk(hdrive_n, !(mp < 2), "R2", "hdrive_n");
    chk(vdrive_n, !(mh < 18), "R7", "vdrive_n");
    chk(frame_n, !(mf == 0 && mh == 0), "R8", "frame_n");
    chk(field, mf[0], "R3", "field");
  endtask

  task automatic step(input bit vr);
    bit req;
    mp = (mp + 1) % 32;
    req = vr || mpend;
    if (mp % 16 == 0) begin
      mpend = 0;
      if (req) begin
        mh = vreset_at_vsync ? 6 : 0;
        mf = (mp == 0) ? 0 : 1;
      end else if (mh == mfl - 1) begin
        mh = 0;
        mf = 1 - mf;
      end else begin
        mh++;
      end
    end else begin
      mpend = req;
    end
  endtask

  task automatic cycle(input bit vr);
    compare();
    vreset = vr;
    @(posedge clk);
    step(vr);
    @(negedge clk);
    vreset = 1'b0;
  endtask

  task automatic run(input int n, input int odds);
    for (int i = 0; i < n; i++) begin
      bit vr = (odds > 0) && ($urandom_range(odds - 1) == 0);
      if (vr) vreset_at_vsync = 1'($urandom_range(1));
      cycle(vr);
    end
  endtask

  task automatic do_reset(input bit m625);
    @(negedge clk);
    rst_n = 1'b0;
    lines625 = m625;
    ref_sync_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    mp = 0; mh = 0; mf = 0; mpend = 0;
    mfl = m625 ? 625 : 525;
    // R1: reset state
    chk(csync_n, 1'b0, "R1", "csync_n in reset");
    chk(hdrive_n, 1'b0, "R1", "hdrive_n in reset");
    chk(vdrive_n, 1'b0, "R1", "vdrive_n in reset");
    chk(frame_n, 1'b0, "R1", "frame_n in reset");
    chk(field, 1'b0, "R1", "field in reset");
    chk(genlocked, 1'b0, "R1", "genlocked in reset");
    rst_n = 1'b1;
  endtask

  // One reference pulse whose falling edge is seen gap clocks after the previous one.
  // Returns at the falling clock edge one clock after the detection edge.
  task automatic ref_pulse(input int gap, output logic gl, output logic hd0, output logic hd1);
    repeat (gap - 2) @(posedge clk);
    @(negedge clk);
    ref_sync_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    gl = genlocked;
    hd0 = hdrive_n;
    @(posedge clk);
    @(negedge clk);
    ref_sync_n = 1'b1;
    hd1 = hdrive_n;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R1 watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic gl, hd0, hd1;
    void'($urandom(32'd7177));

    // Free run, 525-line frame: two full fields (R2..R8)
    do_reset(1'b0);
    run(2 * 525 * 16 + 40, 0);

    // Free run, 625-line frame (R3 field length)
    do_reset(1'b1);
    run(2 * 625 * 16 + 40, 0);

    // Directed vertical reset to the first broad pulse, requested mid half-line (R9)
    do_reset(1'b0);
    run(7, 0);
    vreset_at_vsync = 1'b1;
    cycle(1'b1);
    run(8, 0);
    chk(vdrive_n, 1'b0, "R9", "vdrive_n after load");
    chk(field, 1'b1, "R9", "field after mid-line load");
    run(2, 0);
    chk(csync_n, 1'b0, "R9", "broad pulse body after load");
    run(12, 0);
    chk(csync_n, 1'b1, "R9", "serration after load");
    // Vertical reset to first equalizing pulse exactly at a line-start boundary
    run(1, 0);
    vreset_at_vsync = 1'b0;
    cycle(1'b1);
    chk(frame_n, 1'b0, "R9", "frame_n after line-start load");
    run(600, 0);

    // Random vertical resets mixed into both modes
    do_reset(1'b0);
    run(9000, 400);
    do_reset(1'b1);
    run(9000, 400);

    // Reference sync acquisition (R10), alignment (R11) and loss (R12)
    do_reset(1'b0);
    ref_pulse(40, gl, hd0, hd1);
    chk(genlocked, 1'b0, "R10", "first pulse");
    ref_pulse(32, gl, hd0, hd1);
    ref_pulse(32, gl, hd0, hd1);
    ref_pulse(40, gl, hd0, hd1);
    chk(gl, 1'b0, "R10", "bad interval clears run");
    ref_pulse(32, gl, hd0, hd1);
    ref_pulse(33, gl, hd0, hd1);
    ref_pulse(31, gl, hd0, hd1);
    chk(gl, 1'b0, "R10", "three good intervals");
    ref_pulse(32, gl, hd0, hd1);
    chk(gl, 1'b1, "R10", "fourth good interval");
    ref_pulse(32, gl, hd0, hd1);
    chk(hd0, 1'b0, "R11", "hdrive_n first clock after aligned edge");
    chk(hd1, 1'b0, "R11", "hdrive_n second clock after aligned edge");
    ref_pulse(31, gl, hd0, hd1);
    chk(hd0, 1'b0, "R11", "hdrive_n after early edge");
    chk(hd1, 1'b0, "R11", "hdrive_n second clock after early edge");
    repeat (254) @(posedge clk);
    @(negedge clk);
    chk(genlocked, 1'b1, "R12", "lock held 255 clocks after last edge");
    @(posedge clk);
    @(negedge clk);
    chk(genlocked, 1'b0, "R12", "lock dropped 256 clocks after last edge");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule